// File: doc/BRIEF.md
# Conditional multiply-accumulate unit

This block is a one-cycle multiply-accumulate datapath with a 40-bit accumulator. It holds two small operand banks, one for X and one for Y, each loaded through a write port. On every enabled cycle whose condition input is true, the block reads an X operand and a Y operand, multiplies them, adds the product to the accumulator and writes the sum back. In squaring mode the X operand is used for both multiplier inputs. A format code sets, separately for each operand, whether it is read as signed or unsigned. A further rounding format reads both operands as signed and rounds the sum to bit 16.

The sum can go to one of two places. It can replace the whole accumulator, or its bits 31..16 can go into a 16-bit feedback register. In the second case the accumulator keeps its value. Condition codes are evaluated outside the block and arrive as a single bit. An unconditional operation ties that bit high. If the format code is undefined, or is not allowed with squaring, the block flags an error and writes nothing. A second flag reports a result that does not fit in 32 signed bits.

Top module: `mac_unit`

## Requirements
- R1: After reset, the accumulator, the feedback register, the operand banks and both flags are zero.
- R2: When en and cond_ok are both high and dst_fb is 0, the accumulator takes the value acc + X*Y. The result shows on acc after the next rising clock edge.
- R3: The fmt code sets signedness. 0 means X signed and Y signed. 1 means X signed and Y unsigned. 2 means X unsigned and Y signed. 3 means both unsigned. The product is extended to 40 bits to match.
- R4: When cond_ok is low or en is low, acc and fb keep their values and err and ovf are low in the next cycle.
- R5: When dst_fb is 1, fb takes bits 31..16 of the 40-bit sum and acc keeps its value.
- R6: fmt code 4 reads both operands as signed. It then rounds the sum to a multiple of 0x10000, to the nearest value. A remainder of exactly 0x8000 is rounded so that bit 16 ends up 0.
- R7: When square is 1, both multiplier inputs are the X operand selected by x_sel and y_sel is ignored. Codes 0, 3 and 4 are allowed.
- R8: fmt codes 5 to 7, or codes 1 and 2 with square set, make err high for one cycle. On such an executed operation acc and fb do not change.
- R9: ovf is high for one cycle after an executed, legal operation whose 40-bit sum has bits 39..32 not all equal to bit 31.
- R10: ld_en writes ld_data into entry ld_idx of the X bank (ld_bank 0) or the Y bank (ld_bank 1). An operation in the same cycle reads the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Operand bank write strobe |
| ld_bank | input | 1 | 0 selects the X bank, 1 selects the Y bank |
| ld_idx | input | SW | Bank entry to write |
| ld_data | input | DW | Value to write |
| en | input | 1 | Operation request |
| cond_ok | input | 1 | Evaluated condition; tie high for unconditional |
| x_sel | input | SW | X bank entry to read |
| y_sel | input | SW | Y bank entry to read |
| fmt | input | 3 | Format code (see R3, R6) |
| dst_fb | input | 1 | 1 writes the feedback register, 0 writes the accumulator |
| square | input | 1 | Use the X operand for both multiplier inputs |
| acc | output | AW | Accumulator |
| fb | output | DW | Feedback register |
| ovf | output | 1 | Result does not fit in 32 signed bits |
| err | output | 1 | Illegal format was suppressed |

## Verification
Operands are chosen with their top bits set: -2 and 0xFFFF. With those values each of the four signedness codes gives a different product, so swapping the X and Y signedness, or extending with the wrong sign, shows up in the accumulator. Rounding is tried with remainders 0x8000 below an even bit 16, 0x8000 below an odd bit 16, and a value away from the halfway point. These tell round-half-even apart from plain round-half-up and from truncation. Squaring runs with a Y bank entry that differs from X, which exposes a datapath that reads Y. Illegal codes, false conditions and a load in the same cycle as an operation show whether a write leaks through, or whether the new register value is used too early.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        FMT_SS  = 3'd0,
        FMT_SU  = 3'd1,
        FMT_US  = 3'd2,
        FMT_UU  = 3'd3,
        FMT_RND = 3'd4
    } mac_fmt_e;

    // X operand is read as two's complement
    function automatic logic fmt_x_signed(input logic [2:0] f);
        return (f == FMT_SS) || (f == FMT_SU) || (f == FMT_RND);
    endfunction

    // Y operand is read as two's complement
    function automatic logic fmt_y_signed(input logic [2:0] f);
        return (f == FMT_SS) || (f == FMT_US) || (f == FMT_RND);
    endfunction

    // code defined and allowed for the chosen operand source
    function automatic logic fmt_legal(input logic [2:0] f, input logic sq);
        logic known;
        known = (f <= FMT_RND);
        return known && !(sq && ((f == FMT_SU) || (f == FMT_US)));
    endfunction

endpackage

// File: rtl/mac_opfile.sv
module mac_opfile #(
    parameter int DW   = 16,
    parameter int NREG = 2,
    parameter int SW   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic          ld_bank,
    input  logic [SW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic [SW-1:0] x_sel,
    input  logic [SW-1:0] y_sel,
    output logic [DW-1:0] x_val,
    output logic [DW-1:0] y_val
);

    logic [DW-1:0] xb_q [NREG];
    logic [DW-1:0] yb_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        logic [DW-1:0] xe_d, ye_d;
        logic          hit;

        always_comb begin
            hit  = ld_en && (ld_idx == SW'(g));
            xe_d = (hit && !ld_bank) ? ld_data : xb_q[g];
            ye_d = (hit &&  ld_bank) ? ld_data : yb_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                xb_q[g] <= '0;
                yb_q[g] <= '0;
            end else begin
                xb_q[g] <= xe_d;
                yb_q[g] <= ye_d;
            end
        end
    end

    // out-of-range selects read zero
    always_comb begin
        x_val = '0;
        y_val = '0;
        for (int i = 0; i < NREG; i++) begin
            if (x_sel == SW'(i)) x_val = xb_q[i];
            if (y_sel == SW'(i)) y_val = yb_q[i];
        end
    end

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          x_sgn,
    input  logic          y_sgn,
    output logic [AW-1:0] prod
);

    localparam int EW = DW + 1;
    localparam int PW = 2 * EW;

    logic signed [EW-1:0] xe, ye;
    logic signed [PW-1:0] pf;

    always_comb begin
        xe = $signed({x_sgn & x[DW-1], x});
        ye = $signed({y_sgn & y[DW-1], y});
        pf = xe * ye;
    end

    if (AW > PW) begin : g_ext
        assign prod = {{(AW - PW){pf[PW-1]}}, pf};
    end else begin : g_trunc
        assign prod = pf[AW-1:0];
    end

endmodule

// File: rtl/mac_addrnd.sv
module mac_addrnd #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [AW-1:0] acc_in,
    input  logic [AW-1:0] prod,
    input  logic          rnd,
    output logic [AW-1:0] res,
    output logic          ovf
);

    localparam int HB = 2 * DW - 1;
    localparam logic [AW-1:0] HALF = AW'(1) << (DW - 1);

    logic [AW-1:0] sum, bumped, rounded;
    logic          tie;
    logic [AW-1-HB:0] top;

    always_comb begin
        sum     = acc_in + prod;
        bumped  = sum + HALF;
        tie     = (sum[DW-1:0] == HALF[DW-1:0]);
        rounded = {bumped[AW-1:DW], {DW{1'b0}}};
        if (tie) rounded[DW] = 1'b0;
        res     = rnd ? rounded : sum;
        top     = res[AW-1:HB];
        ovf     = !((&top) || (~|top));
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 40,
    parameter int NREG = 2,
    localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic          ld_bank,
    input  logic [SW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic          en,
    input  logic          cond_ok,
    input  logic [SW-1:0] x_sel,
    input  logic [SW-1:0] y_sel,
    input  logic [2:0]    fmt,
    input  logic          dst_fb,
    input  logic          square,
    output logic [AW-1:0] acc,
    output logic [DW-1:0] fb,
    output logic          ovf,
    output logic          err
);

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [DW-1:0] fb;
        logic          ovf;
        logic          err;
    } mac_st_t;

    mac_st_t st_d, st_q;

    logic [DW-1:0] x_val, y_raw, y_val;
    logic [AW-1:0] prod, res;
    logic          res_ovf, go, legal;

    mac_opfile #(.DW(DW), .NREG(NREG), .SW(SW)) u_opfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_bank (ld_bank),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .x_sel   (x_sel),
        .y_sel   (y_sel),
        .x_val   (x_val),
        .y_val   (y_raw)
    );

    assign y_val = square ? x_val : y_raw;

    mac_mult #(.DW(DW), .AW(AW)) u_mult (
        .x     (x_val),
        .y     (y_val),
        .x_sgn (fmt_x_signed(fmt)),
        .y_sgn (fmt_y_signed(fmt)),
        .prod  (prod)
    );

    mac_addrnd #(.DW(DW), .AW(AW)) u_addrnd (
        .acc_in (st_q.acc),
        .prod   (prod),
        .rnd    (fmt == FMT_RND),
        .res    (res),
        .ovf    (res_ovf)
    );

    always_comb begin
        go        = en && cond_ok;
        legal     = fmt_legal(fmt, square);
        st_d      = st_q;
        st_d.ovf  = 1'b0;
        st_d.err  = 1'b0;
        if (go) begin
            if (!legal) begin
                st_d.err = 1'b1;
            end else begin
                st_d.ovf = res_ovf;
                if (dst_fb) st_d.fb  = res[2*DW-1:DW];
                else        st_d.acc = res;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc = st_q.acc;
    assign fb  = st_q.fb;
    assign ovf = st_q.ovf;
    assign err = st_q.err;

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          cond_ok,
    input logic [2:0]    fmt,
    input logic          dst_fb,
    input logic          square,
    input logic [AW-1:0] acc,
    input logic [DW-1:0] fb,
    input logic          ovf,
    input logic          err
);

    logic bad_fmt;
    assign bad_fmt = (fmt > 3'd4) || (square && ((fmt == 3'd1) || (fmt == 3'd2)));

    a_r4_noop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && cond_ok) |=> $stable(acc) && $stable(fb));

    a_r4_noop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && cond_ok) |=> !err && !ovf);

    a_r5_fb_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        en && cond_ok && dst_fb |=> $stable(acc));

    a_r6_rnd_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        en && cond_ok && (fmt == 3'd4) && !dst_fb |=> acc[DW-1:0] == '0);

    a_r8_illegal_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        en && cond_ok && bad_fmt |=> err && $stable(acc) && $stable(fb));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && ovf));

endmodule

bind mac_unit mac_unit_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .cond_ok (cond_ok),
    .fmt     (fmt),
    .dst_fb  (dst_fb),
    .square  (square),
    .acc     (acc),
    .fb      (fb),
    .ovf     (ovf),
    .err     (err)
);

// File: tb/mac_unit_tb.sv
module mac_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0, ld_bank = 1'b0;
    logic [0:0]    ld_idx = '0;
    logic [DW-1:0] ld_data = '0;
    logic          en = 1'b0, cond_ok = 1'b0;
    logic [0:0]    x_sel = '0, y_sel = '0;
    logic [2:0]    fmt = '0;
    logic          dst_fb = 1'b0, square = 1'b0;
    logic [AW-1:0] acc;
    logic [DW-1:0] fb;
    logic          ovf, err;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] mx [2];
    logic [DW-1:0] my [2];
    logic [AW-1:0] e_acc;
    logic [DW-1:0] e_fb;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_bank(ld_bank),
        .ld_idx(ld_idx), .ld_data(ld_data), .en(en), .cond_ok(cond_ok),
        .x_sel(x_sel), .y_sel(y_sel), .fmt(fmt), .dst_fb(dst_fb),
        .square(square), .acc(acc), .fb(fb), .ovf(ovf), .err(err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // independent reference: 64-bit integer arithmetic
    function automatic logic [AW-1:0] ref_sum(input logic [AW-1:0] a, input logic [DW-1:0] x,
                                              input logic [DW-1:0] y, input int f);
        longint xv, yv, s, lo;
        bit xu, yu;
        xu = (f == 2) || (f == 3);
        yu = (f == 1) || (f == 3);
        xv = xu ? longint'({48'b0, x}) : longint'($signed(x));
        yv = yu ? longint'({48'b0, y}) : longint'($signed(y));
        s  = longint'($signed(a)) + xv * yv;
        if (f == 4) begin
            lo = s & 64'hFFFF;
            s  = s - lo;
            if (lo > 64'h8000 || (lo == 64'h8000 && s[16])) s = s + 64'h10000;
        end
        return s[AW-1:0];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mx = '{default: '0};
        my = '{default: '0};
        e_acc = '0;
        e_fb  = '0;
    endtask

    task automatic load(input logic bank, input int idx, input logic [DW-1:0] d);
        ld_en = 1'b1; ld_bank = bank; ld_idx = idx[0:0]; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        if (bank) my[idx] = d; else mx[idx] = d;
    endtask

    // one operation; checks acc, fb, err, ovf one edge later
    task automatic op(input string tag, input logic c, input int xs, input int ys,
                      input int f, input logic d, input logic sq);
        logic [DW-1:0] xv, yv;
        logic [AW-1:0] r;
        logic legal, e_err, e_ovf;
        xv = mx[xs];
        yv = sq ? xv : my[ys];
        legal = (f <= 4) && !(sq && (f == 1 || f == 2));
        e_err = 1'b0; e_ovf = 1'b0;
        r = ref_sum(e_acc, xv, yv, f);
        if (c) begin
            if (!legal) e_err = 1'b1;
            else begin
                e_ovf = !((&r[AW-1:31]) || !(|r[AW-1:31]));
                if (d) e_fb = r[31:16]; else e_acc = r;
            end
        end
        en = 1'b1; cond_ok = c; x_sel = xs[0:0]; y_sel = ys[0:0];
        fmt = f[2:0]; dst_fb = d; square = sq;
        @(negedge clk);
        en = 1'b0;
        chk({tag, " acc"}, 64'(acc), 64'(e_acc));
        chk({tag, " fb"},  64'(fb),  64'(e_fb));
        chk({tag, " err"}, 64'(err), 64'(e_err));
        chk({tag, " ovf"}, 64'(ovf), 64'(e_ovf));
    endtask

    task automatic t_reset();
        chk("R1 reset acc", 64'(acc), 0);
        chk("R1 reset fb", 64'(fb), 0);
        chk("R1 reset flags", 64'({ovf, err}), 0);
        op("R1 bank zero", 1'b1, 1, 1, 0, 1'b0, 1'b0);
    endtask

    task automatic t_formats();
        load(1'b0, 0, 16'd3);
        load(1'b0, 1, 16'hFFFE);
        load(1'b1, 0, 16'd5);
        load(1'b1, 1, 16'hFFFF);
        op("R2 ss pos", 1'b1, 0, 0, 0, 1'b0, 1'b0);
        chk("R2 acc value", 64'(acc), 64'd15);
        op("R3 ss neg", 1'b1, 1, 1, 0, 1'b0, 1'b0);
        op("R3 uu", 1'b1, 1, 1, 3, 1'b0, 1'b0);
        op("R3 su", 1'b1, 1, 1, 1, 1'b0, 1'b0);
        op("R3 us", 1'b1, 1, 1, 2, 1'b0, 1'b0);
        op("R3 su mixed", 1'b1, 1, 0, 1, 1'b0, 1'b0);
    endtask

    task automatic t_noop();
        op("R4 cond false", 1'b0, 1, 1, 3, 1'b0, 1'b0);
        op("R4 cond false fb", 1'b0, 1, 1, 3, 1'b1, 1'b0);
        en = 1'b0; cond_ok = 1'b1; fmt = 3'd3;
        @(negedge clk);
        chk("R4 en low acc", 64'(acc), 64'(e_acc));
        chk("R4 en low flags", 64'({ovf, err}), 0);
    endtask

    task automatic t_fbdest();
        load(1'b0, 0, 16'h4000);
        load(1'b1, 0, 16'h4000);
        op("R5 fb dest", 1'b1, 0, 0, 0, 1'b1, 1'b0);
        op("R5 fb dest uu", 1'b1, 1, 1, 3, 1'b1, 1'b0);
    endtask

    task automatic t_round();
        do_reset();
        load(1'b0, 0, 16'h8000);
        load(1'b0, 1, 16'd0);
        load(1'b1, 0, 16'd1);
        load(1'b1, 1, 16'd3);
        op("R6 setup", 1'b1, 0, 0, 3, 1'b0, 1'b0);
        op("R6 tie even down", 1'b1, 1, 0, 4, 1'b0, 1'b0);
        chk("R6 tie even value", 64'(acc), 0);
        op("R6 setup odd", 1'b1, 0, 1, 3, 1'b0, 1'b0);
        op("R6 tie odd up", 1'b1, 1, 0, 4, 1'b0, 1'b0);
        chk("R6 tie odd value", 64'(acc), 64'h20000);
        load(1'b0, 1, 16'h7FFF);
        op("R6 signed above half", 1'b1, 1, 1, 4, 1'b0, 1'b0);
        load(1'b1, 1, 16'hFFFD);
        op("R6 signed negative", 1'b1, 1, 1, 4, 1'b0, 1'b0);
        op("R6 rnd to fb", 1'b1, 1, 1, 4, 1'b1, 1'b0);
    endtask

    task automatic t_square();
        load(1'b0, 0, 16'hFFFD);
        load(1'b1, 0, 16'd7);
        op("R7 square ss", 1'b1, 0, 0, 0, 1'b0, 1'b1);
        load(1'b0, 1, 16'hFFFF);
        op("R7 square uu", 1'b1, 1, 0, 3, 1'b0, 1'b1);
        op("R7 square rnd", 1'b1, 0, 0, 4, 1'b0, 1'b1);
    endtask

    task automatic t_illegal();
        op("R8 square su", 1'b1, 0, 0, 1, 1'b0, 1'b1);
        op("R8 square us", 1'b1, 0, 0, 2, 1'b1, 1'b1);
        op("R8 code 5", 1'b1, 0, 0, 5, 1'b0, 1'b0);
        op("R8 code 7", 1'b1, 0, 0, 7, 1'b1, 1'b0);
        op("R8 cond false no err", 1'b0, 0, 0, 6, 1'b0, 1'b0);
    endtask

    task automatic t_overflow();
        do_reset();
        load(1'b0, 0, 16'hFFFF);
        load(1'b1, 0, 16'hFFFF);
        load(1'b0, 1, 16'd1);
        load(1'b1, 1, 16'd1);
        op("R9 small no ovf", 1'b1, 1, 1, 0, 1'b0, 1'b0);
        op("R9 uu ovf", 1'b1, 0, 0, 3, 1'b0, 1'b0);
        chk("R9 ovf high", 64'(ovf), 1);
        op("R9 fb dest ovf", 1'b1, 1, 1, 0, 1'b1, 1'b0);
        op("R9 ovf stays", 1'b1, 1, 1, 0, 1'b0, 1'b0);
        en = 1'b0;
        @(negedge clk);
        chk("R9 ovf pulse", 64'(ovf), 0);
    endtask

    task automatic t_load_same_cycle();
        do_reset();
        load(1'b0, 0, 16'd2);
        load(1'b1, 0, 16'd9);
        ld_en = 1'b1; ld_bank = 1'b0; ld_idx = 1'b0; ld_data = 16'd100;
        op("R10 old x used", 1'b1, 0, 0, 0, 1'b0, 1'b0);
        mx[0] = 16'd100;
        chk("R10 old x value", 64'(acc), 64'd18);
        op("R10 new x used", 1'b1, 0, 0, 0, 1'b0, 1'b0);
        chk("R10 new x value", 64'(acc), 64'd918);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        finish_run();
    end

    initial begin
        mx = '{default: '0};
        my = '{default: '0};
        e_acc = '0;
        e_fb  = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_formats();
        t_noop();
        t_fbdest();
        t_round();
        t_square();
        t_illegal();
        t_overflow();
        t_load_same_cycle();
        finish_run();
    end

endmodule